// File: doc/BRIEF.md
# Multidrop Serial Receiver with Address Filtering

This block recovers asynchronous serial frames from a shared multidrop line. It decides in hardware whether each frame should raise the receive-complete flag. A frame carries either eight data bits or nine. In the nine-bit formats, the ninth bit marks the frame as an address frame (1) or a data frame (0). When multiprocessor filtering is switched on, a station raises its flag only for address frames that name it. A frame names the station if it matches the station's own masked address or the broadcast address, and it must also end with a valid stop bit. All other frames are dropped without a trace.

The usual protocol runs as follows. A station waits with filtering on. When it is addressed, software reads the byte, turns filtering off, and then takes the data frames that follow. Stations that were not addressed keep filtering on and never see those data frames.

The serial input is oversampled through a baud-tick enable that pulses at sixteen times the bit rate.

Top module: `mpu_addr_rx`

## Requirements
- R1: `mode_sel` selects the frame format. Codes 2'b00 and 2'b01 carry 8 data bits. Codes 2'b10 and 2'b11 carry 9 data bits. Data bits arrive LSB first, after a low start bit and before a high stop bit. `rx_data` takes the first eight bits. In the 9-bit formats, `rx_bit8` takes the ninth bit; in the 8-bit formats it takes the stop-bit level.
- R2: With `mp_en` low, every completed frame raises `rx_flag`, whatever its ninth bit and whatever its stop-bit level.
- R3: In the 9-bit formats with `mp_en` high, a frame whose ninth bit is 0 never raises `rx_flag`.
- R4: In the 9-bit formats with `mp_en` high, a frame whose ninth bit is 1 raises `rx_flag` only if its byte matches the own or the broadcast address and its stop bit is high.
- R5: The own address matches when the received byte equals `dev_addr` in every bit position where `dev_mask` is 1. Mask-0 bits are don't-care. With mask 8'hFF only the exact address matches. Address 8'h56 with mask 8'hFC matches every byte of the form 0101_01xx.
- R6: The broadcast address is `dev_addr | dev_mask`. A received byte matches it when the byte has a 1 in every position where that OR is 1.
- R7: In code 2'b01 with `mp_en` high, a frame raises `rx_flag` only if its byte matches (as in R5 or R6) and its stop bit is high.
- R8: In code 2'b00, `mp_en` has no effect, and every completed frame raises `rx_flag`.
- R9: A frame that completes while `rx_flag` is already 1 is discarded. `rx_data`, `rx_bit8` and `rx_frame_ok` keep the earlier frame.
- R10: `rx_flag` stays 1 until `flag_clr` is pulsed. Reset clears every output to 0.
- R11: `rx_data`, `rx_bit8` and `rx_frame_ok` change only when a frame raises `rx_flag`.
- R12: Each bit is decided by a majority of the 7th, 8th and 9th oversamples. A start bit that reads high at mid-bit is rejected as a glitch. A one-sample spike inside a bit does not corrupt that bit.
- R13: `rx_frame_ok` shows the stop-bit level of the last accepted frame: 1 for a valid stop bit, 0 for a framing error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| baud_tick | input | 1 | One-cycle enable at 16x bit rate |
| rxd | input | 1 | Serial line, idle high |
| mode_sel | input | 2 | Frame format code |
| mp_en | input | 1 | Multiprocessor filtering enable |
| dev_addr | input | 8 | Station address |
| dev_mask | input | 8 | Address mask, 0 = don't-care |
| flag_clr | input | 1 | Clears the receive flag |
| rx_data | output | 8 | Last accepted data byte |
| rx_bit8 | output | 1 | Ninth bit (or stop level) of last accepted frame |
| rx_flag | output | 1 | Receive-complete flag |
| rx_frame_ok | output | 1 | Stop bit of last accepted frame was valid |

## Verification
Proving that a frame was dropped, rather than merely slow to arrive, is hard to do from the ports. The stimulus therefore leaves the flag clear and runs a full stop bit plus an idle bit past the end of every frame. The bench then checks that the flag stayed low and that the held byte is still the previous one. The overrun case needs a frame to complete while an earlier one is still unread. To set this up, the monitor's automatic flag clearing is suspended, so that a second matching frame lands on a set flag.

A spurious start pulse and a one-sample spike in mid-bit are timed on the same 16x grid that the receiver samples. This shows that the majority vote and the glitch rejection work at the exact sample points.

// File: rtl/mpr_pkg.sv
package mpr_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_START,
    ST_DATA,
    ST_STOP,
    ST_BREAK
  } rx_state_t;

  localparam logic [1:0] MODE_SHIFT = 2'b00;
  localparam logic [1:0] MODE_8BIT  = 2'b01;
endpackage

// File: rtl/mpr_sync.sv
module mpr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) chain <= '1;
    else     chain <= {chain[STAGES-2:0], din};
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/mpr_frame.sv
module mpr_frame
  import mpr_pkg::*;
#(
  parameter int OSR = 16,
  parameter int DW  = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          tick,
  input  logic          rxd_s,
  input  logic          nine,
  output logic          done,
  output logic [DW-1:0] data,
  output logic          bit9,
  output logic          stop_ok,
  output logic          is_nine
);
  localparam int CW = $clog2(OSR);
  localparam int BW = $clog2(DW + 2);
  localparam logic [CW-1:0] C_VA   = CW'(OSR / 2 - 2);
  localparam logic [CW-1:0] C_VB   = CW'(OSR / 2 - 1);
  localparam logic [CW-1:0] C_VC   = CW'(OSR / 2);
  localparam logic [CW-1:0] C_LAST = CW'(OSR - 1);

  rx_state_t     st;
  logic [CW-1:0] cnt;
  logic [BW-1:0] bitn;
  logic [DW:0]   sh;
  logic [1:0]    vote;
  logic          nine_r;
  logic          stop_r;
  logic          maj;
  logic [BW-1:0] last_bit;

  assign maj      = (vote[0] & vote[1]) | (vote[0] & rxd_s) | (vote[1] & rxd_s);
  assign last_bit = nine_r ? BW'(DW) : BW'(DW - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      cnt    <= '0;
      bitn   <= '0;
      sh     <= '0;
      vote   <= '0;
      nine_r <= 1'b0;
      stop_r <= 1'b0;
      done   <= 1'b0;
    end else begin
      done <= 1'b0;
      if (st == ST_BREAK) begin
        if (rxd_s) st <= ST_IDLE;
      end else if (tick) begin
        if (st == ST_IDLE) begin
          if (!rxd_s) begin
            st     <= ST_START;
            cnt    <= '0;
            nine_r <= nine;
          end
        end else begin
          cnt <= (cnt == C_LAST) ? '0 : cnt + 1'b1;
          if (cnt == C_VA) vote[0] <= rxd_s;
          if (cnt == C_VB) vote[1] <= rxd_s;
          unique case (st)
            ST_START: begin
              if (cnt == C_VC && maj) st <= ST_IDLE;
              else if (cnt == C_LAST) begin
                st   <= ST_DATA;
                bitn <= '0;
              end
            end
            ST_DATA: begin
              if (cnt == C_VC) sh <= {maj, sh[DW:1]};
              if (cnt == C_LAST) begin
                if (bitn == last_bit) st <= ST_STOP;
                else bitn <= bitn + 1'b1;
              end
            end
            ST_STOP: begin
              if (cnt == C_VC) begin
                done   <= 1'b1;
                stop_r <= maj;
                st     <= maj ? ST_IDLE : ST_BREAK;
              end
            end
            default: st <= ST_IDLE;
          endcase
        end
      end
    end
  end

  assign data    = nine_r ? sh[DW-1:0] : sh[DW:1];
  assign bit9    = nine_r ? sh[DW] : stop_r;
  assign stop_ok = stop_r;
  assign is_nine = nine_r;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);  // R1
  AST_GLITCH_BACK: assert property (@(posedge clk) disable iff (rst)
    (st == ST_START && tick && cnt == C_VC && maj) |=> (st == ST_IDLE));  // R12
endmodule

// File: rtl/mpr_match.sv
module mpr_match
  import mpr_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [DW-1:0] data,
  input  logic          bit9,
  input  logic          stop_ok,
  input  logic          is_nine,
  input  logic [1:0]    mode,
  input  logic          mp_en,
  input  logic [DW-1:0] addr,
  input  logic [DW-1:0] mask,
  output logic          accept
);
  logic [DW-1:0] bcast;
  logic          hit_own;
  logic          hit_all;
  logic          hit;
  logic          filt;

  assign bcast   = addr | mask;
  assign hit_own = ((data ^ addr) & mask) == '0;
  assign hit_all = ((data ^ bcast) & bcast) == '0;
  assign hit     = hit_own | hit_all;
  assign filt    = mp_en && (mode != MODE_SHIFT);

  always_comb begin
    if (!filt)        accept = 1'b1;
    else if (is_nine) accept = bit9 && hit && stop_ok;
    else              accept = hit && stop_ok;
  end
endmodule

// File: rtl/mpu_addr_rx.sv
module mpu_addr_rx
  import mpr_pkg::*;
#(
  parameter int OSR       = 16,
  parameter int DW        = 8,
  parameter int SYNC_DEPTH = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          baud_tick,
  input  logic          rxd,
  input  logic [1:0]    mode_sel,
  input  logic          mp_en,
  input  logic [DW-1:0] dev_addr,
  input  logic [DW-1:0] dev_mask,
  input  logic          flag_clr,
  output logic [DW-1:0] rx_data,
  output logic          rx_bit8,
  output logic          rx_flag,
  output logic          rx_frame_ok
);
  logic          rxd_s;
  logic          f_done;
  logic [DW-1:0] f_data;
  logic          f_bit9;
  logic          f_stop;
  logic          f_nine;
  logic          accept;

  mpr_sync #(.STAGES(SYNC_DEPTH)) u_sync (
    .clk (clk),
    .rst (rst),
    .din (rxd),
    .dout(rxd_s)
  );

  mpr_frame #(.OSR(OSR), .DW(DW)) u_frame (
    .clk    (clk),
    .rst    (rst),
    .tick   (baud_tick),
    .rxd_s  (rxd_s),
    .nine   (mode_sel[1]),
    .done   (f_done),
    .data   (f_data),
    .bit9   (f_bit9),
    .stop_ok(f_stop),
    .is_nine(f_nine)
  );

  mpr_match #(.DW(DW)) u_match (
    .data   (f_data),
    .bit9   (f_bit9),
    .stop_ok(f_stop),
    .is_nine(f_nine),
    .mode   (mode_sel),
    .mp_en  (mp_en),
    .addr   (dev_addr),
    .mask   (dev_mask),
    .accept (accept)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_data     <= '0;
      rx_bit8     <= 1'b0;
      rx_flag     <= 1'b0;
      rx_frame_ok <= 1'b0;
    end else begin
      if (flag_clr) rx_flag <= 1'b0;
      if (f_done && accept && !rx_flag) begin
        rx_data     <= f_data;
        rx_bit8     <= f_bit9;
        rx_frame_ok <= f_stop;
        rx_flag     <= 1'b1;
      end
    end
  end

  AST_OPEN_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (f_done && !rx_flag && (!mp_en || mode_sel == MODE_SHIFT)) |=> rx_flag);  // R2
  AST_DATA_FRAME_DROP: assert property (@(posedge clk) disable iff (rst)
    (f_done && f_nine && mp_en && !f_bit9 && !rx_flag) |=> !rx_flag);  // R3
  AST_OVERRUN_HOLD: assert property (@(posedge clk) disable iff (rst)
    rx_flag |=> ($stable(rx_data) && $stable(rx_bit8) && $stable(rx_frame_ok)));  // R9
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
    (rx_flag && !flag_clr) |=> rx_flag);  // R10
  AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (rx_flag && flag_clr) |=> !rx_flag);  // R10
  AST_QUIET_OUT: assert property (@(posedge clk) disable iff (rst)
    !f_done |=> ($stable(rx_data) && $stable(rx_bit8)));  // R11
endmodule

// File: tb/sim_mpu_addr_rx.sv
module sim_mpu_addr_rx;
  localparam int BITCLK = 64;

  typedef struct packed {
    logic [7:0] data;
    logic       b8;
    logic       ok;
  } item_t;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       baud_tick;
  logic       rxd = 1'b1;
  logic [1:0] mode_sel = 2'b10;
  logic       mp_en = 1'b0;
  logic [7:0] dev_addr = 8'h00;
  logic [7:0] dev_mask = 8'hFF;
  logic       clr_auto = 1'b0;
  logic       clr_man = 1'b0;
  logic       flag_clr;
  logic [7:0] rx_data;
  logic       rx_bit8, rx_flag, rx_frame_ok;

  int    errors = 0;
  int    checks = 0;
  logic  auto_clr = 1'b1;
  logic  prevf = 1'b0;
  logic [1:0] tdiv = 2'd0;
  item_t q[$];

  always #2.5 clk = ~clk;
  always_ff @(posedge clk) tdiv <= tdiv + 2'd1;
  assign baud_tick = (tdiv == 2'd3);
  assign flag_clr  = clr_auto | clr_man;

  mpu_addr_rx u0 (
    .clk(clk), .rst(rst), .baud_tick(baud_tick), .rxd(rxd),
    .mode_sel(mode_sel), .mp_en(mp_en), .dev_addr(dev_addr),
    .dev_mask(dev_mask), .flag_clr(flag_clr), .rx_data(rx_data),
    .rx_bit8(rx_bit8), .rx_flag(rx_flag), .rx_frame_ok(rx_frame_ok)
  );

  task automatic chk(input logic cond, input string req, input logic [15:0] act,
                     input logic [15:0] exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic model_accept(input logic [7:0] d, input logic b9,
                                        input logic stopv);
    logic [7:0] bc;
    logic own, all;
    bc  = dev_addr | dev_mask;
    own = ((d ^ dev_addr) & dev_mask) == 8'h00;
    all = ((d & bc) == bc);
    if (!mp_en || mode_sel == 2'b00) return 1'b1;
    if (mode_sel[1]) return b9 && (own || all) && stopv;
    return (own || all) && stopv;
  endfunction

  task automatic drive_bit(input logic v, input int spike);
    rxd = v;
    if (spike) begin
      repeat (BITCLK/2 - 2) @(negedge clk);
      rxd = ~v;
      repeat (4) @(negedge clk);
      rxd = v;
      repeat (BITCLK/2 - 2) @(negedge clk);
    end else begin
      repeat (BITCLK) @(negedge clk);
    end
  endtask

  // Driver: pushes the expected item, shifts the frame out, then checks at the ports.
  task automatic send(input logic [7:0] d, input logic b9, input logic stopv,
                      input int spike_bit, input string req);
    logic exp;
    item_t it;
    exp = model_accept(d, b9, stopv);
    it.data = d;
    it.b8   = mode_sel[1] ? b9 : stopv;
    it.ok   = stopv;
    if (exp && auto_clr) q.push_back(it);
    drive_bit(1'b0, 0);
    for (int i = 0; i < 8; i++) drive_bit(d[i], (i == spike_bit) ? 1 : 0);
    if (mode_sel[1]) drive_bit(b9, 0);
    drive_bit(stopv, 0);
    drive_bit(1'b1, 0);
    repeat (BITCLK) @(negedge clk);
    if (auto_clr) begin
      if (exp) chk(q.size() == 0, req, 16'(q.size()), 16'd0);
      else     chk(rx_flag == 1'b0, req, 16'(rx_flag), 16'd0);
    end
  endtask

  // Monitor: pops the expected item when the flag rises and compares outputs.
  always @(negedge clk) begin
    if (rst) begin
      prevf    = 1'b0;
      clr_auto = 1'b0;
    end else begin
      clr_auto = 1'b0;
      if (rx_flag && !prevf) begin
        if (q.size() == 0) begin
          if (auto_clr) chk(1'b0, "R2/R3/R4/R7 unexpected flag", {8'h0, rx_data}, 16'h0);
        end else begin
          item_t e;
          e = q.pop_front();
          chk(rx_data == e.data, "R1 data", {8'h0, rx_data}, {8'h0, e.data});
          chk(rx_bit8 == e.b8, "R1 bit8", 16'(rx_bit8), 16'(e.b8));
          chk(rx_frame_ok == e.ok, "R13 frame_ok", 16'(rx_frame_ok), 16'(e.ok));
        end
        if (auto_clr) clr_auto = 1'b1;
      end
      prevf = rx_flag;
    end
  end

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog actual=running expected=done");
    finish_run();
  end

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(rx_flag == 0 && rx_data == 0 && rx_bit8 == 0 && rx_frame_ok == 0,
        "R10 reset", {rx_flag, rx_bit8, rx_frame_ok, 5'h0, rx_data}, 16'h0);

    // R1 R2: 9-bit, filtering off
    mode_sel = 2'b10; mp_en = 1'b0;
    send(8'hA5, 1'b0, 1'b1, -1, "R2 9-bit open");
    mode_sel = 2'b11;
    send(8'h3C, 1'b1, 1'b0, -1, "R2 R13 bad stop open");

    // R3 R4 R5: 9-bit filtering, exact address
    mode_sel = 2'b10; mp_en = 1'b1; dev_addr = 8'h56; dev_mask = 8'hFF;
    send(8'h56, 1'b0, 1'b1, -1, "R3 data frame dropped");
    chk(rx_data == 8'h3C, "R11 held after drop", {8'h0, rx_data}, 16'h003C);
    send(8'h56, 1'b1, 1'b1, -1, "R4 R5 exact match");
    send(8'h57, 1'b1, 1'b1, -1, "R5 exact mismatch");
    send(8'h56, 1'b1, 1'b0, -1, "R4 bad stop dropped");
    chk(rx_frame_ok == 1'b1, "R11 ok held", 16'(rx_frame_ok), 16'd1);

    // R5 R6: mask with don't-cares, broadcast
    dev_mask = 8'hFC;
    send(8'h55, 1'b1, 1'b1, -1, "R5 masked match");
    send(8'h5A, 1'b1, 1'b1, -1, "R5 masked mismatch");
    send(8'hFE, 1'b1, 1'b1, -1, "R6 broadcast");
    send(8'hFF, 1'b1, 1'b1, -1, "R6 broadcast all ones");

    // R7: 8-bit filtering
    mode_sel = 2'b01;
    send(8'h54, 1'b0, 1'b1, -1, "R7 match good stop");
    send(8'h54, 1'b0, 1'b0, -1, "R7 match bad stop dropped");
    send(8'h13, 1'b0, 1'b1, -1, "R7 mismatch dropped");

    // R8: shift-mode code ignores mp_en
    mode_sel = 2'b00;
    send(8'h13, 1'b0, 1'b0, -1, "R8 filter ignored");

    // R12: spike within a data bit, then a glitch start
    mode_sel = 2'b10; mp_en = 1'b0;
    send(8'hC3, 1'b0, 1'b1, 3, "R12 spike rejected");
    rxd = 1'b0;
    repeat (8) @(negedge clk);
    rxd = 1'b1;
    repeat (4 * BITCLK) @(negedge clk);
    chk(rx_flag == 1'b0, "R12 glitch start", 16'(rx_flag), 16'd0);
    send(8'h81, 1'b1, 1'b1, -1, "R12 recover after glitch");

    // R9 R10: overrun
    auto_clr = 1'b0;
    send(8'h11, 1'b0, 1'b1, -1, "R9 first");
    chk(rx_flag == 1'b1 && rx_data == 8'h11, "R10 flag held", {7'h0, rx_flag, rx_data}, 16'h0111);
    send(8'h22, 1'b1, 1'b1, -1, "R9 second");
    chk(rx_data == 8'h11 && rx_bit8 == 1'b0, "R9 overrun discarded",
        {7'h0, rx_bit8, rx_data}, 16'h0011);
    chk(rx_flag == 1'b1, "R10 sticky", 16'(rx_flag), 16'd1);
    clr_man = 1'b1;
    @(negedge clk);
    clr_man = 1'b0;
    @(negedge clk);
    chk(rx_flag == 1'b0 && rx_data == 8'h11, "R10 cleared",
        {7'h0, rx_flag, rx_data}, 16'h0011);
    prevf = 1'b0;
    auto_clr = 1'b1;
    chk(q.size() == 0, "R2 queue drained", 16'(q.size()), 16'd0);
    finish_run();
  end
endmodule